// File: doc/BRIEF.md
# Parallel 6x6 Matrix Multiplier

This block forms the product C = A x B of two square matrices of signed fixed-point numbers. There are six multiply-accumulate lanes. Lane k always produces column k of C, and all six lanes work on the same row of C at the same time. To make this possible, each row of A has its own operand bank and each column of B has its own operand bank. In every step, the six lanes fetch their operands in parallel: they share one element of A and each takes its own element of B.

A row of C takes six accumulation steps. The six finished sums are then pushed into a small output FIFO, column 0 first. The next row starts only after the sixth sum has been pushed. Matrices are loaded one element at a time through a valid/ready write port. A one-cycle `start` pulse begins a product. A one-cycle `done` pulse marks the moment the last of the 36 sums has entered the FIFO.

Results leave through a valid/ready stream. When the consumer holds `out_ready` low, the FIFO fills and the engine stalls without losing any result.

Top module: `mat6_mul`

## Requirements
- R1: A write handshake (`wr_valid` and `wr_ready` both high at a clock edge) stores `wr_data` at row `wr_row`, column `wr_col`. It goes into matrix A when `wr_mat`=0 and into matrix B when `wr_mat`=1. Row and column indices run from 0 to 5.
- R2: After reset, `busy`=0, `done`=0, `out_valid`=0 and `wr_ready`=1.
- R3: Each result equals the sum over j of A[r][j]*B[j][c]. It is computed with signed arithmetic at full precision, 2*DW+3 bits wide, with no truncation and no overflow.
- R4: The 36 results leave in row-major order: rows 0 to 5, and within a row, columns 0 to 5.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. A result is consumed at an edge where both are high.
- R6: When `out_ready` is held low, the engine stalls and does not push into a full FIFO. Exactly 36 results come out, none lost and none repeated.
- R7: `done` is high for exactly one cycle per product. That cycle follows the edge at which the 36th result entered the FIFO, and `busy` is low in that same cycle.
- R8: A `start` pulse while `busy` is high is ignored. The run is not restarted, and no extra results or `done` pulses appear.
- R9: When `out_ready` is held high, `done` arrives within 80 cycles of `start`, well inside a 400-cycle budget.
- R10: While `busy` is high, `wr_ready` is low. A write offered then is not stored, and a later product of the same matrices is unchanged.
- R11: Extreme operands (every element at the most negative value, or at the most positive value) give the exact sums 6*(2^(DW-1))^2 and 6*(2^(DW-1)-1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Element write offered |
| wr_ready | output | 1 | Write port accepts (engine idle) |
| wr_mat | input | 1 | 0 selects matrix A, 1 selects matrix B |
| wr_row | input | 3 | Row index of the element |
| wr_col | input | 3 | Column index of the element |
| wr_data | input | DW (36) | Signed element value |
| start | input | 1 | Begin a product (honoured only when idle) |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle pulse after the final result enters the FIFO |
| out_valid | output | 1 | FIFO holds a result |
| out_ready | input | 1 | Consumer takes the head result |
| out_data | output | 2*DW+3 (75) | Signed result element |

## Verification
Two things can coincide in one cycle: the engine pushing a result into the FIFO and the consumer popping the FIFO head. Both also overlap with the engine stalling on a full FIFO. The bench provokes this by holding `out_ready` low long enough to fill the FIFO, then releasing it only every third cycle. Pushes and pops then interleave at the full boundary. The bench judges the outcome by the exact count of 36 results, their row-major order, their values against sums it computes itself, and a single `done` pulse.

// File: rtl/mat6_mul_pkg.sv
package mat6_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MAC   = 2'd1,
    ST_DRAIN = 2'd2
  } mm_state_e;
endpackage

// File: rtl/mat6_mul_bank.sv
module mat6_mul_bank #(
  parameter int N  = 6,
  parameter int DW = 36
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [DW-1:0]        wdata,
  input  logic [$clog2(N)-1:0] raddr,
  output logic [DW-1:0]        rdata
);
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mat6_mul_lane.sv
module mat6_mul_lane #(
  parameter int DW = 36,
  parameter int AW = 75
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clr,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [AW-1:0] acc
);
  localparam int PW = 2 * DW;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;

  assign prod     = a * b;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= (clr ? '0 : acc) + prod_ext;
  end
endmodule

// File: rtl/mat6_mul_fifo.sv
module mat6_mul_fifo #(
  parameter int W     = 75,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [PW:0]   cnt;

  assign full  = (cnt == (PW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end
endmodule

// File: rtl/mat6_mul.sv
module mat6_mul #(
  parameter int N          = 6,
  parameter int DW         = 36,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid,
  output logic                        wr_ready,
  input  logic                        wr_mat,
  input  logic [$clog2(N)-1:0]        wr_row,
  input  logic [$clog2(N)-1:0]        wr_col,
  input  logic [DW-1:0]               wr_data,
  input  logic                        start,
  output logic                        busy,
  output logic                        done,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [2*DW+$clog2(N)-1:0]   out_data
);
  import mat6_mul_pkg::*;

  localparam int IW = $clog2(N);
  localparam int AW = 2 * DW + IW;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  mm_state_e     state;
  logic [IW-1:0] row, step, idx;
  logic          wr_fire, fifo_full, fifo_empty, fifo_push, fifo_pop;

  logic [DW-1:0]        a_rd [N];
  logic [DW-1:0]        b_rd [N];
  logic signed [AW-1:0] lane_acc [N];
  logic [DW-1:0]        a_sel;

  assign wr_ready  = (state == ST_IDLE);
  assign wr_fire   = wr_valid && wr_ready;
  assign busy      = (state != ST_IDLE);
  assign a_sel     = a_rd[row];
  assign fifo_push = (state == ST_DRAIN) && !fifo_full;
  assign out_valid = !fifo_empty;
  assign fifo_pop  = out_valid && out_ready;

  for (genvar g = 0; g < N; g++) begin : g_bank
    // Row g of A, addressed by column index
    mat6_mul_bank #(.N(N), .DW(DW)) u_a (
      .clk(clk), .we(wr_fire && !wr_mat && wr_row == IW'(g)),
      .waddr(wr_col), .wdata(wr_data), .raddr(step), .rdata(a_rd[g]));
    // Column g of B, addressed by row index
    mat6_mul_bank #(.N(N), .DW(DW)) u_b (
      .clk(clk), .we(wr_fire && wr_mat && wr_col == IW'(g)),
      .waddr(wr_row), .wdata(wr_data), .raddr(step), .rdata(b_rd[g]));
    mat6_mul_lane #(.DW(DW), .AW(AW)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(state == ST_MAC), .clr(step == '0),
      .a(a_sel), .b(b_rd[g]), .acc(lane_acc[g]));
  end

  mat6_mul_fifo #(.W(AW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(lane_acc[idx]),
    .pop(fifo_pop), .rdata(out_data), .full(fifo_full), .empty(fifo_empty));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      row   <= '0;
      step  <= '0;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_MAC;
          row   <= '0;
          step  <= '0;
        end
        ST_MAC: begin
          if (step == LAST) begin
            step  <= '0;
            idx   <= '0;
            state <= ST_DRAIN;
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_DRAIN: if (fifo_push) begin
          if (idx == LAST) begin
            if (row == LAST) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              row   <= row + 1'b1;
              state <= ST_MAC;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mat6_mul_chk.sv
module mat6_mul_chk #(
  parameter int OW = 75
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          wr_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic          fifo_full,
  input logic          fifo_push
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_no_write_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_push);
endmodule

bind mat6_mul mat6_mul_chk #(.OW(2*DW+$clog2(N))) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .wr_ready(wr_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .fifo_full(fifo_full), .fifo_push(fifo_push));

// File: tb/tb_mat6_mul.sv
module tb_mat6_mul;
  localparam int N  = 6;
  localparam int DW = 36;
  localparam int OW = 2 * DW + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_mat = 1'b0;
  logic [2:0] wr_row = '0, wr_col = '0;
  logic [DW-1:0] wr_data = '0;
  logic start = 1'b0, out_ready = 1'b0;
  logic wr_ready, busy, done, out_valid;
  logic [OW-1:0] out_data;

  int n_tests = 0, n_fail = 0;
  logic signed [OW-1:0] ma [N][N];
  logic signed [OW-1:0] mb [N][N];
  logic signed [OW-1:0] expv [N*N];

  always #4 clk = ~clk;

  mat6_mul dut (.*);

  task automatic check(input bit ok, input string req, input logic [OW-1:0] act,
                       input logic [OW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Fills the matrices, writes them through the port, computes the expected sums
  task automatic load_and_expect();
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        for (int m = 0; m < 2; m++) begin
          @(negedge clk);
          wr_valid = 1'b1; wr_mat = m[0]; wr_row = 3'(r); wr_col = 3'(c);
          wr_data  = (m == 0) ? ma[r][c][DW-1:0] : mb[r][c][DW-1:0];
        end
      end
    end
    @(negedge clk) wr_valid = 1'b0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        logic signed [OW-1:0] s = '0;
        for (int j = 0; j < N; j++) s = s + ma[r][j] * mb[j][c];
        expv[r*N+c] = s;
      end
  endtask

  // Runs one product; ready_mod/hold_off shape back-pressure, poke tests busy-time inputs
  task automatic run_mat(input int ready_mod, input int hold_off, input bit poke,
                         input string tag);
    int got = 0, dones = 0, cyc = 0, done_cyc = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while ((got < N*N || dones == 0) && cyc < 3000) begin
      cyc++;
      if (poke) begin
        start = (cyc == 20);                              // R8 start while busy
        if (cyc == 30) begin                              // R10 write while busy
          wr_valid = 1'b1; wr_mat = 1'b0; wr_row = '0; wr_col = '0; wr_data = 36'd999;
          check(wr_ready == 1'b0, "R10 wr_ready low while busy", OW'(wr_ready), '0);
        end else wr_valid = 1'b0;
      end
      if (done) begin
        dones++;
        done_cyc = cyc;
        check(busy == 1'b0, {"R7 busy low with done ", tag}, OW'(busy), '0);
      end
      out_ready = (cyc > hold_off) && (cyc % ready_mod == 0);
      if (out_valid && out_ready) begin
        if (got < N*N)
          check(out_data == expv[got], $sformatf("R3 R4 %s element %0d", tag, got),
                out_data, expv[got]);
        got++;
      end
      @(negedge clk);
    end
    start = 1'b0; wr_valid = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (out_valid) got++;
      if (done) dones++;
      @(negedge clk);
    end
    check(got == N*N, {"R6 R8 result count ", tag}, OW'(got), OW'(N*N));
    check(dones == 1, {"R7 R8 single done ", tag}, OW'(dones), 1);
    if (ready_mod == 1 && hold_off == 0)
      check(done_cyc > 0 && done_cyc <= 80, {"R9 latency ", tag}, OW'(done_cyc), 80);
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R2 busy after reset", OW'(busy), 0);
    check(done == 1'b0, "R2 done after reset", OW'(done), 0);
    check(out_valid == 1'b0, "R2 out_valid after reset", OW'(out_valid), 0);
    check(wr_ready == 1'b1, "R2 wr_ready after reset", OW'(wr_ready), 1);
  endtask

  task automatic t_small();   // R1 R3 R4 R9 small mixed-sign values, free flow
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = OW'(r*N + c - 10);
        mb[r][c] = OW'((r - c) * 3);
      end
    load_and_expect();
    run_mat(1, 0, 1'b0, "small");
  endtask

  task automatic t_wide_busy(); // R5 R6 R8 R10 back-pressure plus busy-time inputs
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = OW'($signed(36'($urandom()) << (r + 2)));
        mb[r][c] = OW'($signed(36'($urandom()) ^ 36'(c << 33)));
      end
    load_and_expect();
    run_mat(3, 40, 1'b1, "stall");
    run_mat(1, 0, 1'b0, "rerun");   // R10 refused write left A[0][0] intact
  endtask

  task automatic t_extreme();  // R11 extreme operands
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = -(OW'(1) << (DW-1));
        mb[r][c] = -(OW'(1) << (DW-1));
      end
    load_and_expect();
    check(expv[0] == OW'(6) * (OW'(1) << (2*DW-2)), "R11 expected neg extreme",
          expv[0], OW'(6) * (OW'(1) << (2*DW-2)));
    run_mat(2, 0, 1'b0, "negext");
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = (OW'(1) << (DW-1)) - 1;
        mb[r][c] = (OW'(1) << (DW-1)) - 1;
      end
    load_and_expect();
    run_mat(1, 0, 1'b0, "posext");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_wide_busy();
    t_extreme();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule